// File: doc/BRIEF.md
# DRAM Bank Command Timing Checker

This block sits between a memory controller's command scheduler and the command pins of a four-bank double-data-rate SDRAM. Every clock the scheduler presents at most one candidate command (activate, read, write, precharge of one bank or of all banks, or auto refresh) together with a bank number, the row for an activate and the A10 bit. The block answers in the same cycle with a grant when the command breaks no spacing rule, or with a one-cycle violation pulse when it does. A rejected command changes nothing.

Internally each bank keeps its open row and a set of down-counters that say how many cycles must still pass before an activate, a column access or a precharge becomes legal. Two shared counters cover spacing between banks: activate to activate on different banks, and write data to a following read. Every limit is given in nanoseconds as a parameter and turned into clock cycles at elaboration. Minimum limits round up and the maximum open time rounds down. At the default 6 ns period this gives tRCD 3, tRP 3, tRAS 7 to 11666, tRC 10, tRRD 2, tWR 3 and tRFC 20 cycles. Write data is taken to end 3 cycles after the WRITE command, and read data 2 cycles after the READ command.

The block also handles auto-precharge. A read or write with A10 high stops the bank from accepting further column commands at once. The bank then precharges itself in the first cycle in which an explicit precharge would have been legal.

Top module: `dram_bank_timing`

## Requirements
- R1: After a granted activate on a bank, read or write to that bank is rejected for 2 cycles and granted in the 3rd cycle after it (tRCD).
- R2: After a precharge of an open bank, whether explicit or the internal one from auto-precharge, an activate to that bank is refused until 3 cycles after that precharge (tRP).
- R3: A precharge of a bank is refused until 7 cycles after its activate (tRAS minimum), and a second activate of the same bank is refused until 10 cycles after the first (tRC).
- R4: An activate to any bank is refused in the cycle after an activate to another bank and allowed 2 cycles after it (tRRD).
- R5: A precharge of a bank is refused until 6 cycles after a write to it: 3 cycles of write data plus 3 cycles of write recovery.
- R6: A read to any bank is refused until 4 cycles after a write: 3 cycles of write data plus 1 cycle of tWTR.
- R7: A read or write with a10=1 is granted as normal and closes the bank at once, so bank_open drops and further reads and writes to it are refused. The bank precharges itself in the first cycle in which R3/R5 (or the 2-cycle read window) allow it, and R2 then counts from that cycle.
- R8: A precharge with a10=1 closes every open bank and is granted only when each open bank may be precharged and no auto-precharge is pending. A single-bank precharge (a10=0) to an idle bank is granted and changes no state.
- R9: Auto refresh is granted only when no bank is open, none has an auto-precharge pending and no bank's activate window is running. After it, any activate is refused until 20 cycles later (tRFC).
- R10: If a bank is still open 11666 cycles after its activate, the violation flag pulses once in that cycle (tRAS maximum). A command granted in that same cycle is still granted.
- R11: Command codes are 0 activate, 1 read, 2 write, 3 precharge and 4 auto refresh. Codes 5 to 7 are rejected. Any rejected request drives viol=1 and grant=0 for that cycle and leaves bank state and open rows unchanged.
- R12: A read or write to a bank with no open row is rejected. An activate to a bank that is already open is rejected.
- R13: After reset no bank is open, grant and viol are 0, and every timing window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | A command is requested this cycle |
| cmd | input | 3 | Command code (see R11) |
| bank | input | 2 | Target bank |
| a10 | input | 1 | Auto-precharge on read/write, all banks on precharge |
| row | input | 13 | Row address for an activate |
| grant | output | 1 | The requested command may be issued this cycle |
| viol | output | 1 | Rule broken this cycle (rejected request or tRAS overrun) |
| bank_open | output | 4 | Bit b set while bank b has an open row that accepts column commands |
| open_row | output | 52 | Open row of bank b in bits [13*b +: 13] |

## Verification
Two things can happen in the same cycle: a command grant and the tRAS-maximum overrun pulse from a bank that was left open. Both drive the same flag. The bench leaves bank 0 open until its overrun cycle and requests an activate on bank 1 in exactly that cycle. It expects grant and viol both high, with viol quiet in the cycles just before and just after. The internal auto-precharge and a command in the same cycle are also covered. A write with auto-precharge is followed by an activate to the same bank one cycle before and exactly on the cycle that the internal precharge plus tRP allows.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_RD  = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_REF = 3'd4
  } dbt_cmd_e;

  // minimum limit: round up to whole clocks
  function automatic int unsigned ns_to_ck_up(int unsigned ns, int unsigned ck_ns);
    return (ns + ck_ns - 1) / ck_ns;
  endfunction

  // maximum limit: round down to whole clocks
  function automatic int unsigned ns_to_ck_dn(int unsigned ns, int unsigned ck_ns);
    return ns / ck_ns;
  endfunction

  // a window of n cycles loads n-1; the command is legal again when the count is 0
  function automatic int unsigned win_load(int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/dbt_bank.sv
module dbt_bank #(
  parameter int CW         = 6,
  parameter int AGE_W      = 14,
  parameter int ROW_W      = 13,
  parameter int RC_LD      = 9,
  parameter int RCD_LD     = 2,
  parameter int RAS_LD     = 6,
  parameter int RP_LD      = 2,
  parameter int RFC_LD     = 19,
  parameter int RD_PRE_LD  = 1,
  parameter int WR_PRE_LD  = 5,
  parameter int RAS_MAX_CK = 11666
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_ap,
  input  logic             do_pre,
  input  logic             do_ref,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             act_ready,
  output logic             rw_ready,
  output logic             pre_ready,
  output logic             ap_pend,
  output logic             idle_ready,
  output logic             ap_fire,
  output logic             ras_expire
);
  localparam logic [CW-1:0]    RC_V   = CW'(RC_LD);
  localparam logic [CW-1:0]    RCD_V  = CW'(RCD_LD);
  localparam logic [CW-1:0]    RAS_V  = CW'(RAS_LD);
  localparam logic [CW-1:0]    RP_V   = CW'(RP_LD);
  localparam logic [CW-1:0]    RFC_V  = CW'(RFC_LD);
  localparam logic [CW-1:0]    RDP_V  = CW'(RD_PRE_LD);
  localparam logic [CW-1:0]    WRP_V  = CW'(WR_PRE_LD);
  localparam logic [AGE_W-1:0] AGE_MX = AGE_W'(RAS_MAX_CK);

  logic [CW-1:0]    act_cnt, rw_cnt, pre_cnt;
  logic [CW-1:0]    act_n, rw_n, pre_n;
  logic [AGE_W-1:0] age, age_n;
  logic             open_n, ap_n, close_now;

  function automatic logic [CW-1:0] dec(logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(logic [CW-1:0] a, logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign ap_fire    = ap_pend && (pre_cnt == '0);
  assign close_now  = do_pre || ((do_rd || do_wr) && do_ap);
  assign act_ready  = !is_open && !ap_pend && (act_cnt == '0);
  assign rw_ready   = is_open && (rw_cnt == '0);
  assign pre_ready  = (pre_cnt == '0);
  assign idle_ready = act_ready;
  assign ras_expire = is_open && (age == AGE_MX) && !close_now;

  always_comb begin
    act_n  = dec(act_cnt);
    rw_n   = dec(rw_cnt);
    pre_n  = dec(pre_cnt);
    open_n = is_open;
    ap_n   = ap_pend;
    age_n  = age;
    if (do_act) begin
      act_n  = RC_V;
      rw_n   = RCD_V;
      pre_n  = RAS_V;
      open_n = 1'b1;
      age_n  = AGE_W'(1);
    end else if (is_open && (age <= AGE_MX)) begin
      age_n = age + 1'b1;
    end
    if (do_rd) pre_n = mx(pre_n, RDP_V);
    if (do_wr) pre_n = mx(pre_n, WRP_V);
    if (close_now) open_n = 1'b0;
    if ((do_rd || do_wr) && do_ap) ap_n = 1'b1;
    if (ap_fire) ap_n = 1'b0;
    if (do_pre || ap_fire) act_n = mx(act_n, RP_V);
    if (do_ref) act_n = mx(act_n, RFC_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cnt <= '0;
      rw_cnt  <= '0;
      pre_cnt <= '0;
      age     <= '0;
      is_open <= 1'b0;
      ap_pend <= 1'b0;
      row_q   <= '0;
    end else begin
      act_cnt <= act_n;
      rw_cnt  <= rw_n;
      pre_cnt <= pre_n;
      age     <= age_n;
      is_open <= open_n;
      ap_pend <= ap_n;
      if (do_act) row_q <= row_in;
    end
  end
endmodule

// File: rtl/dbt_spacing.sv
module dbt_spacing #(
  parameter int CW     = 6,
  parameter int RRD_LD = 1,
  parameter int WTR_LD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act,
  input  logic any_wr,
  output logic rrd_ready,
  output logic wtr_ready
);
  localparam logic [CW-1:0] RRD_V = CW'(RRD_LD);
  localparam logic [CW-1:0] WTR_V = CW'(WTR_LD);

  logic [CW-1:0] rrd_cnt, wtr_cnt;

  assign rrd_ready = (rrd_cnt == '0);
  assign wtr_ready = (wtr_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      wtr_cnt <= '0;
    end else begin
      if (any_act)           rrd_cnt <= RRD_V;
      else if (!rrd_ready)   rrd_cnt <= rrd_cnt - 1'b1;
      if (any_wr)            wtr_cnt <= WTR_V;
      else if (!wtr_ready)   wtr_cnt <= wtr_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dbt_rules.sv
module dbt_rules #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic            req,
  input  logic [2:0]      cmd,
  input  logic [BA_W-1:0] bank,
  input  logic            a10,
  input  logic [NB-1:0]   is_open,
  input  logic [NB-1:0]   act_ready,
  input  logic [NB-1:0]   rw_ready,
  input  logic [NB-1:0]   pre_ready,
  input  logic [NB-1:0]   ap_pend,
  input  logic [NB-1:0]   idle_ready,
  input  logic            rrd_ready,
  input  logic            wtr_ready,
  output logic            grant,
  output logic            reject
);
  import dbt_pkg::*;

  logic ok, all_pre_ok, one_pre_ok;

  assign all_pre_ok = &(~ap_pend & (~is_open | pre_ready));
  assign one_pre_ok = !ap_pend[bank] && (!is_open[bank] || pre_ready[bank]);

  always_comb begin
    case (cmd)
      CMD_ACT: ok = act_ready[bank] && rrd_ready;
      CMD_RD:  ok = rw_ready[bank] && wtr_ready;
      CMD_WR:  ok = rw_ready[bank];
      CMD_PRE: ok = a10 ? all_pre_ok : one_pre_ok;
      CMD_REF: ok = &idle_ready;
      default: ok = 1'b0;
    endcase
  end

  assign grant  = req && ok;
  assign reject = req && !ok;
endmodule

// File: rtl/dram_bank_timing.sv
module dram_bank_timing #(
  parameter int CK_NS        = 6,
  parameter int T_RCD_NS     = 18,
  parameter int T_RP_NS      = 18,
  parameter int T_RAS_MIN_NS = 42,
  parameter int T_RAS_MAX_NS = 70000,
  parameter int T_RC_NS      = 60,
  parameter int T_RRD_NS     = 12,
  parameter int T_WR_NS      = 15,
  parameter int T_RFC_NS     = 120,
  parameter int T_WTR_CK     = 1,
  parameter int WR_DATA_CK   = 3,
  parameter int RD_PRE_CK    = 2,
  parameter int ROW_W        = 13,
  parameter int NUM_BANKS    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic [2:0]                 cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] bank,
  input  logic                       a10,
  input  logic [ROW_W-1:0]           row,
  output logic                       grant,
  output logic                       viol,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row
);
  import dbt_pkg::*;

  localparam int BA_W       = $clog2(NUM_BANKS);
  localparam int RCD_CK     = ns_to_ck_up(T_RCD_NS, CK_NS);
  localparam int RP_CK      = ns_to_ck_up(T_RP_NS, CK_NS);
  localparam int RAS_CK     = ns_to_ck_up(T_RAS_MIN_NS, CK_NS);
  localparam int RAS_MAX_CK = ns_to_ck_dn(T_RAS_MAX_NS, CK_NS);
  localparam int RC_CK      = ns_to_ck_up(T_RC_NS, CK_NS);
  localparam int RRD_CK     = ns_to_ck_up(T_RRD_NS, CK_NS);
  localparam int WR_CK      = ns_to_ck_up(T_WR_NS, CK_NS);
  localparam int RFC_CK     = ns_to_ck_up(T_RFC_NS, CK_NS);
  localparam int WRPRE_CK   = WR_DATA_CK + WR_CK;
  localparam int WTR_TOT_CK = WR_DATA_CK + T_WTR_CK;
  localparam int CW         = $clog2(RC_CK + RFC_CK + WRPRE_CK + RAS_CK + RCD_CK + 2);
  localparam int AGE_W      = $clog2(RAS_MAX_CK + 2);

  logic [NUM_BANKS-1:0] act_ready, rw_ready, pre_ready, ap_pend, idle_ready;
  logic [NUM_BANKS-1:0] ap_fire, ras_expire;
  logic                 rrd_ready, wtr_ready, reject;
  logic                 g_act, g_rd, g_wr, g_pre, g_ref;

  // named command events for the checker
  assign g_act = grant && (cmd == CMD_ACT);
  assign g_rd  = grant && (cmd == CMD_RD);
  assign g_wr  = grant && (cmd == CMD_WR);
  assign g_pre = grant && (cmd == CMD_PRE);
  assign g_ref = grant && (cmd == CMD_REF);

  dbt_rules #(.NB(NUM_BANKS), .BA_W(BA_W)) u_rules (
    .req(req), .cmd(cmd), .bank(bank), .a10(a10),
    .is_open(bank_open), .act_ready(act_ready), .rw_ready(rw_ready),
    .pre_ready(pre_ready), .ap_pend(ap_pend), .idle_ready(idle_ready),
    .rrd_ready(rrd_ready), .wtr_ready(wtr_ready),
    .grant(grant), .reject(reject)
  );

  dbt_spacing #(.CW(CW), .RRD_LD(win_load(RRD_CK)), .WTR_LD(win_load(WTR_TOT_CK))) u_spacing (
    .clk(clk), .rst_n(rst_n), .any_act(g_act), .any_wr(g_wr),
    .rrd_ready(rrd_ready), .wtr_ready(wtr_ready)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BA_W'(b));
    dbt_bank #(
      .CW(CW), .AGE_W(AGE_W), .ROW_W(ROW_W),
      .RC_LD(win_load(RC_CK)), .RCD_LD(win_load(RCD_CK)), .RAS_LD(win_load(RAS_CK)),
      .RP_LD(win_load(RP_CK)), .RFC_LD(win_load(RFC_CK)),
      .RD_PRE_LD(win_load(RD_PRE_CK)), .WR_PRE_LD(win_load(WRPRE_CK)),
      .RAS_MAX_CK(RAS_MAX_CK)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(g_act && hit),
      .do_rd(g_rd && hit),
      .do_wr(g_wr && hit),
      .do_ap(a10),
      .do_pre(g_pre && bank_open[b] && (a10 || hit)),
      .do_ref(g_ref),
      .row_in(row),
      .is_open(bank_open[b]),
      .row_q(open_row[b*ROW_W +: ROW_W]),
      .act_ready(act_ready[b]), .rw_ready(rw_ready[b]), .pre_ready(pre_ready[b]),
      .ap_pend(ap_pend[b]), .idle_ready(idle_ready[b]),
      .ap_fire(ap_fire[b]), .ras_expire(ras_expire[b])
    );
  end

  assign viol = reject || (|ras_expire);
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NB     = 4,
  parameter int BA_W   = 2,
  parameter int RP_CK  = 3,
  parameter int RRD_CK = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            grant,
  input logic            viol,
  input logic            a10,
  input logic [BA_W-1:0] bank,
  input logic [NB-1:0]   bank_open,
  input logic [NB-1:0]   ras_expire,
  input logic            g_act,
  input logic            g_rd,
  input logic            g_wr,
  input logic            g_pre,
  input logic            g_ref
);
  // R11
  reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |-> viol);

  // R11
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && (ras_expire == '0)) |-> !viol);

  // R12
  col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_rd || g_wr) |-> bank_open[bank]);

  // R9
  refresh_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_ref |-> (bank_open == '0));

  // R8
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_pre && a10) |=> (bank_open == '0));

  // R7
  ap_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((g_rd || g_wr) && a10) |=> !bank_open[$past(bank)]);

  if (RRD_CK > 1) begin : g_rrd
    // R4
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_act |=> !g_act);
  end

  if (RP_CK > 1) begin : g_rp
    // R2
    pre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (g_pre && !a10 && bank_open[bank]) |=> !(g_act && (bank == $past(bank))));
  end
endmodule

bind dram_bank_timing dbt_checker #(
  .NB(NUM_BANKS), .BA_W(BA_W), .RP_CK(RP_CK), .RRD_CK(RRD_CK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .viol(viol), .a10(a10),
  .bank(bank), .bank_open(bank_open), .ras_expire(ras_expire),
  .g_act(g_act), .g_rd(g_rd), .g_wr(g_wr), .g_pre(g_pre), .g_ref(g_ref)
);

// File: tb/dram_bank_timing_test.sv
module dram_bank_timing_test;
  localparam int CK       = 6;
  localparam int RAS_MAX  = 70000 / CK;
  localparam int ROW_W    = 13;
  localparam logic [2:0] ACT = 3'd0, RD = 3'd1, WR = 3'd2, PRE = 3'd3, REF = 3'd4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [2:0]       cmd = '0;
  logic [1:0]       bank = '0;
  logic             a10 = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic             grant, viol;
  logic [3:0]       bank_open;
  logic [4*ROW_W-1:0] open_row;

  int checks = 0;
  int errors = 0;

  dram_bank_timing uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .bank(bank), .a10(a10), .row(row),
    .grant(grant), .viol(viol), .bank_open(bank_open), .open_row(open_row)
  );

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one command in one cycle, judged before the next rising edge
  task automatic issue(logic [2:0] c, logic [1:0] b, logic a, logic [ROW_W-1:0] r,
                       logic exp_ok, string tag);
    @(negedge clk);
    req = 1'b1; cmd = c; bank = b; a10 = a; row = r;
    #1;
    check({tag, " grant"}, {31'd0, grant}, {31'd0, exp_ok});
    check({tag, " viol"}, {31'd0, viol}, {31'd0, !exp_ok});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  // look at state after the edge that ends the current command cycle
  task automatic peek_open(logic [3:0] exp, string tag);
    @(posedge clk);
    #1;
    check(tag, {28'd0, bank_open}, {28'd0, exp});
  endtask

  task automatic close_all();
    idle(12);
    issue(PRE, 2'd0, 1'b1, '0, 1'b1, "close all R8");
    idle(25);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    check("R13 grant", {31'd0, grant}, 32'd0);
    check("R13 viol", {31'd0, viol}, 32'd0);
    check("R13 open", {28'd0, bank_open}, 32'd0);
  endtask

  task automatic t_rcd_ras();
    issue(RD, 2'd0, 1'b0, '0, 1'b0, "R12 read closed");
    issue(ACT, 2'd0, 1'b0, 13'd5, 1'b1, "R1 act");
    peek_open(4'b0001, "R1 open");
    check("R1 row", {19'd0, open_row[0 +: ROW_W]}, 32'd5);
    issue(RD, 2'd0, 1'b0, '0, 1'b0, "R1 read +1");
    issue(RD, 2'd0, 1'b0, '0, 1'b0, "R1 read +2");
    issue(RD, 2'd0, 1'b0, '0, 1'b1, "R1 read +3");
    idle(2);
    issue(PRE, 2'd0, 1'b0, '0, 1'b0, "R3 pre +6");
    issue(PRE, 2'd0, 1'b0, '0, 1'b1, "R3 pre +7");
    peek_open(4'b0000, "R3 closed");
    issue(ACT, 2'd0, 1'b0, 13'd6, 1'b0, "R3 act +8");
    issue(ACT, 2'd0, 1'b0, 13'd6, 1'b0, "R3 act +9");
    issue(ACT, 2'd0, 1'b0, 13'd6, 1'b1, "R3 act +10");
    close_all();
  endtask

  task automatic t_rp();
    issue(ACT, 2'd1, 1'b0, 13'd20, 1'b1, "R2 act");
    idle(8);
    issue(PRE, 2'd1, 1'b0, '0, 1'b1, "R2 pre +9");
    issue(ACT, 2'd1, 1'b0, 13'd21, 1'b0, "R2 act +10");
    issue(ACT, 2'd1, 1'b0, 13'd21, 1'b0, "R2 act +11");
    issue(ACT, 2'd1, 1'b0, 13'd21, 1'b1, "R2 act +12");
    close_all();
  endtask

  task automatic t_rrd();
    issue(ACT, 2'd2, 1'b0, 13'd300, 1'b1, "R4 act b2");
    issue(ACT, 2'd3, 1'b0, 13'd301, 1'b0, "R4 act b3 +1");
    issue(ACT, 2'd3, 1'b0, 13'd301, 1'b1, "R4 act b3 +2");
    issue(ACT, 2'd2, 1'b0, 13'd9, 1'b0, "R12 act open bank");
    peek_open(4'b1100, "R11 open kept");
    check("R11 row kept", {19'd0, open_row[2*ROW_W +: ROW_W]}, 32'd300);
    close_all();
  endtask

  task automatic t_write();
    issue(ACT, 2'd0, 1'b0, 13'd44, 1'b1, "R5 act");
    idle(9);
    issue(WR, 2'd0, 1'b0, '0, 1'b1, "R5 write");
    idle(2);
    issue(RD, 2'd0, 1'b0, '0, 1'b0, "R6 read +3");
    issue(RD, 2'd0, 1'b0, '0, 1'b1, "R6 read +4");
    issue(PRE, 2'd0, 1'b0, '0, 1'b0, "R5 pre +5");
    issue(PRE, 2'd0, 1'b0, '0, 1'b1, "R5 pre +6");
    close_all();
  endtask

  task automatic t_autopre();
    issue(ACT, 2'd1, 1'b0, 13'd77, 1'b1, "R7 act");
    idle(2);
    issue(WR, 2'd1, 1'b1, '0, 1'b1, "R7 write ap");
    peek_open(4'b0000, "R7 closed at once");
    issue(RD, 2'd1, 1'b0, '0, 1'b0, "R12 read after ap");
    idle(6);
    issue(ACT, 2'd1, 1'b0, 13'd78, 1'b0, "R7 act +11");
    issue(ACT, 2'd1, 1'b0, 13'd78, 1'b1, "R7 act +12");
    close_all();
  endtask

  task automatic t_preall_ref();
    issue(ACT, 2'd0, 1'b0, 13'd1, 1'b1, "R8 act b0");
    idle(1);
    issue(ACT, 2'd2, 1'b0, 13'd2, 1'b1, "R8 act b2");
    issue(REF, 2'd0, 1'b0, '0, 1'b0, "R9 ref while open");
    issue(PRE, 2'd1, 1'b0, '0, 1'b1, "R8 pre idle bank");
    peek_open(4'b0101, "R8 idle pre no change");
    idle(3);
    issue(PRE, 2'd0, 1'b1, '0, 1'b0, "R8 pre all early");
    issue(PRE, 2'd0, 1'b1, '0, 1'b1, "R8 pre all");
    peek_open(4'b0000, "R8 all closed");
    issue(REF, 2'd0, 1'b0, '0, 1'b0, "R9 ref in tRP");
    idle(1);
    issue(REF, 2'd0, 1'b0, '0, 1'b1, "R9 ref");
    idle(18);
    issue(ACT, 2'd3, 1'b0, 13'd3, 1'b0, "R9 act +19");
    issue(ACT, 2'd3, 1'b0, 13'd3, 1'b1, "R9 act +20");
    close_all();
  endtask

  task automatic t_invalid();
    issue(3'd5, 2'd0, 1'b0, '0, 1'b0, "R11 code 5");
    issue(3'd7, 2'd1, 1'b1, '0, 1'b0, "R11 code 7");
    peek_open(4'b0000, "R11 no state");
    idle(2);
  endtask

  task automatic t_ras_max();
    issue(ACT, 2'd0, 1'b0, 13'd9, 1'b1, "R10 act");
    for (int k = 1; k < RAS_MAX; k++) begin
      @(negedge clk);
      req = 1'b0;
      #1;
      if (k == RAS_MAX - 1) check("R10 viol before", {31'd0, viol}, 32'd0);
    end
    // overrun cycle of bank 0 coincides with a granted activate on bank 1
    @(negedge clk);
    req = 1'b1; cmd = ACT; bank = 2'd1; a10 = 1'b0; row = 13'd11;
    #1;
    check("R10 grant with overrun", {31'd0, grant}, 32'd1);
    check("R10 viol overrun", {31'd0, viol}, 32'd1);
    @(negedge clk);
    req = 1'b0;
    #1;
    check("R10 viol after", {31'd0, viol}, 32'd0);
    close_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rcd_ras();
    t_rp();
    t_rrd();
    t_write();
    t_autopre();
    t_preall_ref();
    t_invalid();
    t_ras_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule